// File: doc/BRIEF.md
# Table-Paged Register Address Decoder

This block sits behind a byte-addressed serial slave engine and turns each received access (the device address byte, an 8-bit register address and a read/write flag) into a target memory, a channel, a local offset and a validity verdict. One auxiliary device address maps a flat 256-byte store. A pair of main device addresses, one for each transmit channel, share a layout. The lower 128 bytes are always mapped. The upper 128 bytes are paged by a table-select byte that the surrounding logic holds and feeds in.

Tables differ by channel. The general-purpose page is reachable only on channel 0. The two lookup pages pick the per-channel copy. An 8-byte alarm-enable row can be placed in one of two pages. The main device pair can move from its fixed addresses to a programmed address. An access that the decoder cannot place still gets a device acknowledge. It is flagged invalid, a read of it must be answered with FFh, and a write to it is dropped. The verdict is registered and appears one cycle after the request strobe.

Top module: `tbl_page_decoder`

## Requirements
- R1: A device byte whose upper seven bits equal A0h's is the auxiliary device. Every register address 00h–FFh is valid there, with target code 1, offset equal to the address and channel 0. The auxiliary match takes priority over any main address.
- R2: With programmed addressing off, device byte A2h (bit 0 ignored) is main channel 0 and B2h is main channel 1. Any other device byte gets dev_ack=0, reg_ok=0, target 0, offset 0, wr_en=0 and rd_blank=0.
- R3: With programmed addressing on, channel 0 answers at the programmed byte with bit 0 cleared and channel 1 answers at that value XOR 10h. A2h and B2h are then not answered unless they equal one of these two values.
- R4: On a main device, addresses 00h–7Fh are lower memory (target 2), with offset equal to the address and the device's channel, whatever the table-select value.
- R5: Table 01h exists only on channel 0. There, 80h–F7h is the general page (target 3, offset address−80h). On channel 1, every upper address under table 01h is invalid.
- R6: Table 02h maps 80h–FFh on both channels to the control page (target 4, offset address−80h, channel of the device).
- R7: Tables 04h and 06h map 80h–C7h to lookup copies (target 6 and target 7, offset address−80h, channel of the device). C8h–FFh in these tables is invalid.
- R8: The alarm row select input picks where F8h–FFh maps to the alarm row (target 5, offset address−F8h). At 0 it maps in table 01h on channel 0 only. At 1 it maps in table 05h on both channels. Wherever the row is not placed, F8h–FFh is invalid. Table 05h at 80h–F7h is always invalid.
- R9: Table-select values 00h, 03h and 07h–FFh map nothing: every upper address under them is invalid.
- R10: For an invalid access on an answered device: dev_ack=1, reg_ok=0, target 0, offset 0, wr_en=0, and rd_blank equals is_read. For a valid access: wr_en equals the inverse of is_read and rd_blank=0.
- R11: Outputs are registered. rsp_vld rises exactly one cycle after req. In a cycle after no request, and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access strobe, one cycle per access |
| dev_byte | input | 8 | Received device address byte (bit 0 ignored) |
| reg_addr | input | 8 | Register address |
| is_read | input | 1 | 1 = read, 0 = write |
| tbl_sel | input | 8 | Current table-select byte |
| row_in_t5 | input | 1 | Alarm row placement: 0 = table 01h, 1 = table 05h |
| prog_en | input | 1 | Use the programmed main device address |
| prog_dev | input | 8 | Programmed main device address byte |
| rsp_vld | output | 1 | Decode result valid |
| dev_ack | output | 1 | Device address answered |
| reg_ok | output | 1 | Register address maps to storage |
| tgt | output | 3 | Target code (0 none … 7 second lookup) |
| tgt_ch | output | 1 | Channel of the target |
| tgt_off | output | 8 | Offset inside the target |
| wr_en | output | 1 | Write may be applied |
| rd_blank | output | 1 | Read must return FFh |

## Verification
Two functions land on the same address window F8h–FFh: the alarm-row placement and the per-channel existence of table 01h. When the row is placed in table 01h and a channel-1 access selects that table, both apply in the same cycle. The bench drives that combination in directed cases and, through random selection of the device, table, placement and address, in many others. The expected verdict, invalid with a blank read, comes from a bench function built from the requirements. The same holds where the programmed main address coincides with the auxiliary one, which tests the priority rule.

// File: rtl/tbl_page_pkg.sv
// Shared target encoding for the table-paged decoder.
// Assumes 3-bit target codes consumed by the memory mux downstream.
package tbl_page_pkg;
    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_AUX   = 3'd1,
        TGT_LOWER = 3'd2,
        TGT_GEN   = 3'd3,
        TGT_CTRL  = 3'd4,
        TGT_ALARM = 3'd5,
        TGT_LUTM  = 3'd6,
        TGT_LUTA  = 3'd7
    } tgt_e;
endpackage

// File: rtl/tpd_dev_match.sv
// Device address matcher: tells auxiliary from main, and which channel.
// Assumes bit 0 of the device byte is the direction bit and is ignored.
// The auxiliary address wins if a programmed main address equals it.
module tpd_dev_match #(
    parameter logic [7:0] AUX_DEV  = 8'hA0,
    parameter logic [7:0] MAIN_DEV = 8'hA2,
    parameter logic [7:0] CH_XOR   = 8'h10
) (
    input  logic [7:0] dev_byte,
    input  logic       prog_en,
    input  logic [7:0] prog_dev,
    output logic       is_aux,
    output logic       is_main,
    output logic       ch
);
    logic [7:0] main0;
    logic [7:0] main1;
    logic [7:0] dev_n;

    // Pick the main address pair and compare with bit 0 masked off.
    always_comb begin
        main0   = prog_en ? (prog_dev & 8'hFE) : (MAIN_DEV & 8'hFE);
        main1   = main0 ^ CH_XOR;
        dev_n   = dev_byte | 8'h01;
        is_aux  = (dev_n == (AUX_DEV | 8'h01));
        is_main = 1'b0;
        ch      = 1'b0;
        if (!is_aux) begin
            if (dev_n == (main0 | 8'h01)) begin
                is_main = 1'b1;
            end else if (dev_n == (main1 | 8'h01)) begin
                is_main = 1'b1;
                ch      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpd_page_decode.sv
// Register address decoder for one matched device.
// Assumes at most one of is_aux / is_main is set. Lower half is fixed,
// upper half is paged by tbl_sel; unmapped spots return TGT_NONE.
module tpd_page_decode
    import tbl_page_pkg::*;
#(
    parameter logic [7:0] T_GEN    = 8'h01,
    parameter logic [7:0] T_CTRL   = 8'h02,
    parameter logic [7:0] T_LUTM   = 8'h04,
    parameter logic [7:0] T_ROW    = 8'h05,
    parameter logic [7:0] T_LUTA   = 8'h06,
    parameter logic [7:0] GEN_END  = 8'hF7,
    parameter logic [7:0] LUT_END  = 8'hC7,
    parameter logic [7:0] ROW_BASE = 8'hF8
) (
    input  logic       is_aux,
    input  logic       is_main,
    input  logic       ch,
    input  logic [7:0] reg_addr,
    input  logic [7:0] tbl_sel,
    input  logic       row_in_t5,
    output logic       ok,
    output tgt_e       tgt,
    output logic [7:0] off
);
    localparam logic [7:0] UPPER = 8'h80;

    logic in_row;
    logic [7:0] up_off;
    logic [7:0] row_off;

    // Offsets relative to the upper half and to the alarm row.
    always_comb begin
        in_row  = (reg_addr >= ROW_BASE);
        up_off  = reg_addr - UPPER;
        row_off = reg_addr - ROW_BASE;
    end

    // Map the address to a target; anything not placed stays TGT_NONE.
    always_comb begin
        tgt = TGT_NONE;
        off = 8'h00;
        if (is_aux) begin
            tgt = TGT_AUX;
            off = reg_addr;
        end else if (is_main) begin
            if (!reg_addr[7]) begin
                tgt = TGT_LOWER;
                off = reg_addr;
            end else if (tbl_sel == T_GEN) begin
                if (!ch) begin
                    if (in_row) begin
                        if (!row_in_t5) begin
                            tgt = TGT_ALARM;
                            off = row_off;
                        end
                    end else if (reg_addr <= GEN_END) begin
                        tgt = TGT_GEN;
                        off = up_off;
                    end
                end
            end else if (tbl_sel == T_CTRL) begin
                tgt = TGT_CTRL;
                off = up_off;
            end else if (tbl_sel == T_LUTM) begin
                if (reg_addr <= LUT_END) begin
                    tgt = TGT_LUTM;
                    off = up_off;
                end
            end else if (tbl_sel == T_LUTA) begin
                if (reg_addr <= LUT_END) begin
                    tgt = TGT_LUTA;
                    off = up_off;
                end
            end else if (tbl_sel == T_ROW) begin
                if (in_row && row_in_t5) begin
                    tgt = TGT_ALARM;
                    off = row_off;
                end
            end
        end
        ok = (tgt != TGT_NONE);
    end

    // R1: the auxiliary device never yields an invalid register.
    always_comb begin
        if (is_aux) begin
            a_aux_full_r1: assert (ok);
        end
    end
endmodule

// File: rtl/tbl_page_decoder.sv
// Top: registers one decode verdict per request strobe.
// Assumes the table-select byte, row placement and programmed address are
// held stable by the owner of the control registers during a request.
module tbl_page_decoder
    import tbl_page_pkg::*;
#(
    parameter logic [7:0] AUX_DEV  = 8'hA0,
    parameter logic [7:0] MAIN_DEV = 8'hA2,
    parameter logic [7:0] CH_XOR   = 8'h10,
    parameter logic [7:0] ROW_BASE = 8'hF8,
    parameter logic [7:0] LUT_END  = 8'hC7,
    parameter logic [7:0] GEN_END  = 8'hF7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [7:0] dev_byte,
    input  logic [7:0] reg_addr,
    input  logic       is_read,
    input  logic [7:0] tbl_sel,
    input  logic       row_in_t5,
    input  logic       prog_en,
    input  logic [7:0] prog_dev,
    output logic       rsp_vld,
    output logic       dev_ack,
    output logic       reg_ok,
    output logic [2:0] tgt,
    output logic       tgt_ch,
    output logic [7:0] tgt_off,
    output logic       wr_en,
    output logic       rd_blank
);
    localparam logic [7:0] ROW_LEN = 8'hFF - ROW_BASE + 8'h01;

    logic       is_aux;
    logic       is_main;
    logic       ch;
    logic       dec_ok;
    tgt_e       dec_tgt;
    logic [7:0] dec_off;

    tpd_dev_match #(
        .AUX_DEV (AUX_DEV),
        .MAIN_DEV(MAIN_DEV),
        .CH_XOR  (CH_XOR)
    ) u_match (
        .dev_byte(dev_byte),
        .prog_en (prog_en),
        .prog_dev(prog_dev),
        .is_aux  (is_aux),
        .is_main (is_main),
        .ch      (ch)
    );

    tpd_page_decode #(
        .GEN_END (GEN_END),
        .LUT_END (LUT_END),
        .ROW_BASE(ROW_BASE)
    ) u_page (
        .is_aux   (is_aux),
        .is_main  (is_main),
        .ch       (ch),
        .reg_addr (reg_addr),
        .tbl_sel  (tbl_sel),
        .row_in_t5(row_in_t5),
        .ok       (dec_ok),
        .tgt      (dec_tgt),
        .off      (dec_off)
    );

    // Capture the verdict for one request; idle cycles clear everything.
    always_ff @(posedge clk) begin
        if (!rst_n || !req) begin
            rsp_vld  <= 1'b0;
            dev_ack  <= 1'b0;
            reg_ok   <= 1'b0;
            tgt      <= 3'd0;
            tgt_ch   <= 1'b0;
            tgt_off  <= 8'h00;
            wr_en    <= 1'b0;
            rd_blank <= 1'b0;
        end else begin
            rsp_vld  <= 1'b1;
            dev_ack  <= is_aux | is_main;
            reg_ok   <= dec_ok;
            tgt      <= dec_tgt;
            tgt_ch   <= is_main & ch;
            tgt_off  <= dec_off;
            wr_en    <= dec_ok & ~is_read;
            rd_blank <= (is_aux | is_main) & ~dec_ok & is_read;
        end
    end

    // R11: a request is answered on the next cycle.
    p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_vld);

    // R11: no result without a preceding request.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req) |-> (!rsp_vld && !dev_ack && !wr_en && !rd_blank));

    // R10: writes are only released onto mapped storage.
    p_wr_mapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (reg_ok && dev_ack && tgt != 3'd0));

    // R10: a blank read never coexists with a write or a mapped target.
    p_blank_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_blank |-> (!wr_en && !reg_ok && tgt == 3'd0 && tgt_off == 8'h00));

    // R8: the alarm row offset stays inside the row.
    p_row_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == 3'd5) |-> (tgt_off < ROW_LEN));

    // R2: an unanswered device never reports a mapped register.
    p_nack_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !dev_ack) |-> (!reg_ok && !rd_blank && tgt == 3'd0));
endmodule

// File: tb/tbl_page_decoder_bench.sv
// Bench: directed corners plus seeded random accesses, each checked
// against a reference model built from the requirements.
module tbl_page_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [7:0] dev_byte = 8'h00;
    logic [7:0] reg_addr = 8'h00;
    logic       is_read = 1'b0;
    logic [7:0] tbl_sel = 8'h00;
    logic       row_in_t5 = 1'b0;
    logic       prog_en = 1'b0;
    logic [7:0] prog_dev = 8'h00;
    logic       rsp_vld, dev_ack, reg_ok, tgt_ch, wr_en, rd_blank;
    logic [2:0] tgt;
    logic [7:0] tgt_off;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tbl_page_decoder u_tbl_page_decoder (
        .clk(clk), .rst_n(rst_n), .req(req), .dev_byte(dev_byte),
        .reg_addr(reg_addr), .is_read(is_read), .tbl_sel(tbl_sel),
        .row_in_t5(row_in_t5), .prog_en(prog_en), .prog_dev(prog_dev),
        .rsp_vld(rsp_vld), .dev_ack(dev_ack), .reg_ok(reg_ok), .tgt(tgt),
        .tgt_ch(tgt_ch), .tgt_off(tgt_off), .wr_en(wr_en), .rd_blank(rd_blank)
    );

    // Packed expectation: {ack, ok, tgt[2:0], ch, off[7:0], wr, blank}
    function automatic logic [15:0] ref_model(
        input logic [7:0] d, input logic [7:0] a, input logic rd,
        input logic [7:0] ts, input logic r5, input logic pe, input logic [7:0] pd);
        logic ack, main, c, ok;
        logic [2:0] t;
        logic [7:0] o, m0;
        ack = 1'b0; main = 1'b0; c = 1'b0; t = 3'd0; o = 8'h00;
        m0 = pe ? {pd[7:1], 1'b0} : 8'hA2;
        if (d[7:1] == 7'h50) begin                     // R1
            ack = 1'b1; t = 3'd1; o = a;
        end else if (d[7:1] == m0[7:1]) begin          // R2 / R3
            ack = 1'b1; main = 1'b1;
        end else if (d[7:1] == (m0[7:1] ^ 7'h08)) begin
            ack = 1'b1; main = 1'b1; c = 1'b1;
        end
        if (main) begin
            if (a < 8'h80) begin t = 3'd2; o = a; end  // R4
            else if (ts == 8'h01 && !c && a <= 8'hF7) begin t = 3'd3; o = a - 8'h80; end
            else if (ts == 8'h01 && !c && !r5) begin t = 3'd5; o = a - 8'hF8; end
            else if (ts == 8'h02) begin t = 3'd4; o = a - 8'h80; end
            else if (ts == 8'h04 && a <= 8'hC7) begin t = 3'd6; o = a - 8'h80; end
            else if (ts == 8'h06 && a <= 8'hC7) begin t = 3'd7; o = a - 8'h80; end
            else if (ts == 8'h05 && r5 && a >= 8'hF8) begin t = 3'd5; o = a - 8'hF8; end
        end
        ok = (t != 3'd0);
        return {ack, ok, t, main & c, o, ok & ~rd, ack & ~ok & rd};
    endfunction

    task automatic check(input string rq, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, got, exp);
        end
    endtask

    task automatic access(input string rq, input logic [7:0] d, input logic [7:0] a,
                          input logic rd, input logic [7:0] ts, input logic r5,
                          input logic pe, input logic [7:0] pd);
        @(negedge clk);
        req = 1'b1; dev_byte = d; reg_addr = a; is_read = rd;
        tbl_sel = ts; row_in_t5 = r5; prog_en = pe; prog_dev = pd;
        @(negedge clk);
        req = 1'b0;
        total++;
        if (rsp_vld !== 1'b1) begin
            bad++;
            $display("FAIL R11 rsp_vld actual=%b expected=1", rsp_vld);
        end
        check(rq, {dev_ack, reg_ok, tgt, tgt_ch, tgt_off, wr_en, rd_blank},
              ref_model(d, a, rd, ts, r5, pe, pd));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main_seq
        logic [7:0] dv, ad, ts, pd;
        logic [7:0] devs [0:5];
        void'($urandom(32'd1876));
        repeat (3) @(negedge clk);
        check("R11 reset", {7'd0, rsp_vld, dev_ack, reg_ok, tgt, tgt_ch, wr_en, rd_blank}, 16'd0);
        check("R11 reset off", {8'd0, tgt_off}, 16'd0);
        rst_n = 1'b1;
        // R1 auxiliary edges and priority over a programmed main address
        access("R1 aux low", 8'hA0, 8'h00, 1'b0, 8'h09, 1'b0, 1'b0, 8'h00);
        access("R1 aux high", 8'hA1, 8'hFF, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
        access("R1 aux prio", 8'hA0, 8'h90, 1'b0, 8'h02, 1'b0, 1'b1, 8'hA0);
        // R2 fixed pair and foreign address
        access("R2 ch0", 8'hA2, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        access("R2 ch1", 8'hB3, 8'h7F, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
        access("R2 nack", 8'hC4, 8'h10, 1'b1, 8'h02, 1'b0, 1'b0, 8'h00);
        // R3 programmed pair
        access("R3 prog ch0", 8'h60, 8'h85, 1'b0, 8'h02, 1'b0, 1'b1, 8'h61);
        access("R3 prog ch1", 8'h70, 8'h85, 1'b0, 8'h02, 1'b0, 1'b1, 8'h61);
        access("R3 old addr", 8'hA2, 8'h85, 1'b1, 8'h02, 1'b0, 1'b1, 8'h61);
        // R4 lower half ignores table select
        access("R4 lower", 8'hB2, 8'h7F, 1'b0, 8'hEE, 1'b1, 1'b0, 8'h00);
        // R5 general page and its channel restriction
        access("R5 gen end", 8'hA2, 8'hF7, 1'b0, 8'h01, 1'b1, 1'b0, 8'h00);
        access("R5 ch1 none", 8'hB2, 8'h80, 1'b1, 8'h01, 1'b0, 1'b0, 8'h00);
        // R6 control page on both channels
        access("R6 ctrl ch1", 8'hB2, 8'hFF, 1'b0, 8'h02, 1'b0, 1'b0, 8'h00);
        // R7 lookup bounds
        access("R7 lutm end", 8'hA2, 8'hC7, 1'b0, 8'h04, 1'b0, 1'b0, 8'h00);
        access("R7 luta past", 8'hB2, 8'hC8, 1'b0, 8'h06, 1'b0, 1'b0, 8'h00);
        access("R7 luta ch1", 8'hB2, 8'h80, 1'b1, 8'h06, 1'b0, 1'b0, 8'h00);
        // R8 alarm row placement and its collision with table existence
        access("R8 row t1", 8'hA2, 8'hF8, 1'b0, 8'h01, 1'b0, 1'b0, 8'h00);
        access("R8 row t1 ch1", 8'hB2, 8'hFF, 1'b1, 8'h01, 1'b0, 1'b0, 8'h00);
        access("R8 row moved", 8'hA2, 8'hFC, 1'b0, 8'h01, 1'b1, 1'b0, 8'h00);
        access("R8 row t5", 8'hB2, 8'hFF, 1'b0, 8'h05, 1'b1, 1'b0, 8'h00);
        access("R8 t5 body", 8'hA2, 8'hF7, 1'b1, 8'h05, 1'b1, 1'b0, 8'h00);
        // R9 absent tables
        access("R9 t00", 8'hA2, 8'h80, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
        access("R9 t03", 8'hA2, 8'hC0, 1'b0, 8'h03, 1'b0, 1'b0, 8'h00);
        access("R9 t07", 8'hB2, 8'hF8, 1'b1, 8'h07, 1'b1, 1'b0, 8'h00);
        // R10 invalid write is dropped without a blank
        access("R10 bad wr", 8'hA2, 8'hD0, 1'b0, 8'h04, 1'b0, 1'b0, 8'h00);
        // R11 idle cycle clears outputs
        @(negedge clk);
        check("R11 idle", {8'd0, rsp_vld, dev_ack, reg_ok, wr_en, rd_blank, tgt}, 16'd0);
        // Random mix over all requirements
        for (int i = 0; i < 4000; i++) begin
            pd = 8'($urandom);
            devs[0] = 8'hA0; devs[1] = 8'hA2; devs[2] = 8'hB2;
            devs[3] = pd; devs[4] = pd ^ 8'h10; devs[5] = 8'($urandom);
            dv = devs[$urandom_range(5)] | 8'($urandom_range(1));
            ad = ($urandom_range(3) == 0) ? (8'hF8 | 8'($urandom_range(7))) : 8'($urandom);
            ts = ($urandom_range(7) == 0) ? 8'($urandom) : 8'($urandom_range(7));
            access("R1-R10 random", dv, ad, 1'($urandom), ts, 1'($urandom),
                   1'($urandom), pd);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule